// File: doc/BRIEF.md
# Sequential Decimal Significand Multiplier

The block multiplies two decimal floating-point operands at significand level. Each operand arrives as a class code, a sign, a signed binary exponent and an ND-digit BCD significand. The result is a 2·ND-digit BCD product with the summed exponent and the combined sign. Final rounding back to ND digits and packing into a storage format are left to the stage that follows.

The multiplicand's 2x and 5x multiples are formed once, in a preparation cycle. After that, one multiplier digit is retired per clock, least significant digit first. Each digit is recoded as a sum or difference of two entries from the set {0, x, 2x, 5x, 10x}. The resulting partial product is added to a running high part, and the lowest digit of that sum is shifted out into the low half of the product. NaN operands and the zero-times-infinity case are resolved with a fixed priority and take the same latency as a normal product. A leading-zero hint lets the following normaliser choose its shift without scanning the product.

Top module: `bcd_sig_mul`

## Requirements
- R1: When `start` is high while `busy` is low, the operands are captured. From the next cycle, `busy` stays high for ND+1 cycles. `done` is high for exactly one cycle, ND+1 clock edges after the capturing edge, and `busy` is low in that cycle. A `start` while `busy` is high is ignored and does not change the result.
- R2: For two finite operands, `r_sig` is the exact product of the significands as 2·ND BCD digits. Digit i sits in bits 4i+3..4i, and every digit is 0 to 9. For example, 1963 × 8145 gives 15988635.
- R3: Every multiplier digit value 0 to 9, in every position, contributes correctly. The recodings are 1=x, 2=2x, 3=2x+x, 4=5x−x, 5=5x, 6=5x+x, 7=5x+2x, 8=10x−2x and 9=10x−x.
- R4: `r_exp` is the two's-complement sum of `a_exp` and `b_exp`, one bit wider than either. `r_sign` is `a_sign` XOR `b_sign`, for every class.
- R5: Class codes are 0 finite, 1 infinity, 2 quiet NaN and 3 signalling NaN. A signalling NaN operand gives class 2, `r_invalid`=1, and that operand's significand zero-extended into `r_sig`. Operand a is checked before operand b.
- R6: With no signalling NaN present, a quiet NaN operand gives class 2, `r_invalid`=0, and that operand's significand. Operand a is checked before operand b.
- R7: A finite zero times infinity, in either order and with no NaN present, gives class 2, `r_sig`=0 and `r_invalid`=1.
- R8: Infinity times a nonzero finite value or times infinity gives class 1, `r_sig`=0 and `r_invalid`=0.
- R9: For a finite result, `r_lz` is lzc(a)+lzc(b), where lzc counts the leading zero digits of an ND-digit significand (ND for zero). The product has at least `r_lz` leading zero digits. For all other classes `r_lz` is 0.
- R10: A finite zero operand times a finite operand gives class 0 with `r_sig`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| a_cls | input | 2 | Class code of operand a |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | EW | Exponent of operand a, two's complement |
| a_sig | input | 4·ND | BCD significand of operand a |
| b_cls | input | 2 | Class code of operand b |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EW | Exponent of operand b, two's complement |
| b_sig | input | 4·ND | BCD significand of operand b (multiplier) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| r_cls | output | 2 | Result class code |
| r_sign | output | 1 | Result sign |
| r_exp | output | EW+1 | Result exponent |
| r_sig | output | 8·ND | BCD product or NaN payload |
| r_invalid | output | 1 | Invalid-operation flag |
| r_lz | output | $clog2(2·ND+1) | Leading-zero hint for the product |

## Verification
The bench builds the block with its defaults, ND=7 and EW=10, which gives a 14-digit product, an 8-cycle latency and 10-bit exponents. The extreme exponents (511+511 and −512+−512) fill the widened result field exactly. All-nines operands drive every partial-product addition to its largest carry, and multipliers containing each digit 0 to 9 exercise every recoding, including both subtractions. Ignoring a second start while busy, NaN priority between the two operands, and both orders of zero times infinity are each driven directly.

// File: rtl/bcd_mul_pkg.sv
package bcd_mul_pkg;

  localparam logic [1:0] CLS_FIN  = 2'd0;
  localparam logic [1:0] CLS_INF  = 2'd1;
  localparam logic [1:0] CLS_QNAN = 2'd2;
  localparam logic [1:0] CLS_SNAN = 2'd3;

  typedef enum logic [2:0] {MS_NONE, MS_X1, MS_X2, MS_X5, MS_X10} mult_sel_e;

  typedef struct packed {
    mult_sel_e p;
    mult_sel_e q;
    logic      neg;
  } recode_t;

  // One BCD digit position: returns {carry, digit}
  function automatic logic [4:0] digit_add(input logic [3:0] a, input logic [3:0] b,
                                           input logic cin);
    logic [4:0] s;
    s = {1'b0, a} + {1'b0, b} + {4'b0, cin};
    if (s > 5'd9) digit_add = {1'b1, 4'(s - 5'd10)};
    else          digit_add = s;
  endfunction

  function automatic logic [3:0] digit_nines(input logic [3:0] d);
    return 4'd9 - d;
  endfunction

  // Multiplier digit -> p (+/-) q using multiples {0, x, 2x, 5x, 10x}
  function automatic recode_t recode_digit(input logic [3:0] d);
    recode_t r;
    case (d)
      4'd1:    r = recode_t'{MS_X1,  MS_NONE, 1'b0};
      4'd2:    r = recode_t'{MS_X2,  MS_NONE, 1'b0};
      4'd3:    r = recode_t'{MS_X2,  MS_X1,   1'b0};
      4'd4:    r = recode_t'{MS_X5,  MS_X1,   1'b1};
      4'd5:    r = recode_t'{MS_X5,  MS_NONE, 1'b0};
      4'd6:    r = recode_t'{MS_X5,  MS_X1,   1'b0};
      4'd7:    r = recode_t'{MS_X5,  MS_X2,   1'b0};
      4'd8:    r = recode_t'{MS_X10, MS_X2,   1'b1};
      4'd9:    r = recode_t'{MS_X10, MS_X1,   1'b1};
      default: r = recode_t'{MS_NONE, MS_NONE, 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcd_adder.sv
module bcd_adder
  import bcd_mul_pkg::*;
#(
  parameter int ND = 8
) (
  input  logic [4*ND-1:0] a,
  input  logic [4*ND-1:0] b,
  input  logic            sub,
  output logic [4*ND-1:0] sum,
  output logic            cout
);
  // Subtraction adds the nines' complement plus one; cout=1 means no borrow
  logic [ND:0] c;
  assign c[0] = sub;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [3:0] bd;
    assign bd = sub ? digit_nines(b[4*i +: 4]) : b[4*i +: 4];
    assign {c[i+1], sum[4*i +: 4]} = digit_add(a[4*i +: 4], bd, c[i]);
  end

  assign cout = c[ND];
endmodule

// File: rtl/bcd_multiples.sv
module bcd_multiples #(
  parameter int ND = 7,
  localparam int MD = ND + 1
) (
  input  logic [4*ND-1:0] x,
  output logic [4*MD-1:0] m2,
  output logic [4*MD-1:0] m5,
  output logic            ovf
);
  logic [4*MD-1:0] xe, m4;
  logic c2, c4, c5;

  assign xe = {4'b0, x};

  bcd_adder #(.ND(MD)) u_dbl  (.a(xe), .b(xe), .sub(1'b0), .sum(m2), .cout(c2));
  bcd_adder #(.ND(MD)) u_quad (.a(m2), .b(m2), .sub(1'b0), .sum(m4), .cout(c4));
  bcd_adder #(.ND(MD)) u_five (.a(m4), .b(xe), .sub(1'b0), .sum(m5), .cout(c5));

  // Any carry out of MD digits means a multiple lost its top digit
  assign ovf = c2 | c4 | c5;
endmodule

// File: rtl/bcd_recode.sv
module bcd_recode
  import bcd_mul_pkg::*;
(
  input  logic [3:0] digit,
  output mult_sel_e  sel_p,
  output mult_sel_e  sel_q,
  output logic       neg
);
  recode_t r;
  always_comb r = recode_digit(digit);
  assign sel_p = r.p;
  assign sel_q = r.q;
  assign neg   = r.neg;
endmodule

// File: rtl/bcd_sig_mul.sv
module bcd_sig_mul
  import bcd_mul_pkg::*;
#(
  parameter int ND = 7,
  parameter int EW = 10,
  localparam int LZW = $clog2(2*ND+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      a_cls,
  input  logic            a_sign,
  input  logic [EW-1:0]   a_exp,
  input  logic [4*ND-1:0] a_sig,
  input  logic [1:0]      b_cls,
  input  logic            b_sign,
  input  logic [EW-1:0]   b_exp,
  input  logic [4*ND-1:0] b_sig,
  output logic            busy,
  output logic            done,
  output logic [1:0]      r_cls,
  output logic            r_sign,
  output logic [EW:0]     r_exp,
  output logic [8*ND-1:0] r_sig,
  output logic            r_invalid,
  output logic [LZW-1:0]  r_lz
);
  localparam int MD  = ND + 1;
  localparam int PD  = ND + 2;
  localparam int CW  = $clog2(ND + 1);
  localparam int LTW = $clog2(ND + 3);

  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_RUN} st_e;

  st_e              st_q;
  logic [1:0]       acls_q, bcls_q;
  logic             asgn_q, bsgn_q;
  logic [EW-1:0]    aexp_q, bexp_q;
  logic [4*ND-1:0]  asig_q, bsig_q, bsh_q;
  logic [4*MD-1:0]  m1_q, m2_q, m5_q, m10_q;
  logic [4*PD-1:0]  hi_q;
  logic [4*ND-1:0]  lo_q;
  logic [CW-1:0]    cnt_q;

  // named internal events
  logic accept, last_step;
  assign accept    = start && (st_q == ST_IDLE);
  assign last_step = (st_q == ST_RUN) && (cnt_q == CW'(ND - 1));
  assign busy      = (st_q != ST_IDLE);

  // multiples of the multiplicand
  logic [4*MD-1:0] m2_w, m5_w;
  logic            mult_ovf;
  bcd_multiples #(.ND(ND)) u_mult (.x(asig_q), .m2(m2_w), .m5(m5_w), .ovf(mult_ovf));

  // recoding of the current multiplier digit
  mult_sel_e rc_p, rc_q;
  logic      rc_neg;
  bcd_recode u_rec (.digit(bsh_q[3:0]), .sel_p(rc_p), .sel_q(rc_q), .neg(rc_neg));

  function automatic logic [4*PD-1:0] pick(input mult_sel_e s,
                                            input logic [4*MD-1:0] x1, input logic [4*MD-1:0] x2,
                                            input logic [4*MD-1:0] x5, input logic [4*MD-1:0] x10);
    case (s)
      MS_X1:   return {4'b0, x1};
      MS_X2:   return {4'b0, x2};
      MS_X5:   return {4'b0, x5};
      MS_X10:  return {4'b0, x10};
      default: return '0;
    endcase
  endfunction

  logic [4*PD-1:0] op_p, op_q, pp, acc_sum;
  logic            pp_cout, acc_cout;
  assign op_p = pick(rc_p, m1_q, m2_q, m5_q, m10_q);
  assign op_q = pick(rc_q, m1_q, m2_q, m5_q, m10_q);

  bcd_adder #(.ND(PD)) u_pp  (.a(op_p), .b(op_q), .sub(rc_neg), .sum(pp), .cout(pp_cout));
  bcd_adder #(.ND(PD)) u_acc (.a(hi_q), .b(pp), .sub(1'b0), .sum(acc_sum), .cout(acc_cout));

  // full product as it stands after the final step
  logic [8*ND-1:0] prod_w;
  assign prod_w = {acc_sum[4*MD-1:0], lo_q[4*ND-1:4]};

  // leading-zero digit counts of the operands
  logic [LZW-1:0] lza, lzb;
  always_comb begin
    lza = LZW'(ND);
    lzb = LZW'(ND);
    for (int i = 0; i < ND; i++) begin
      if (asig_q[4*i +: 4] != 4'd0) lza = LZW'(ND - 1 - i);
      if (bsig_q[4*i +: 4] != 4'd0) lzb = LZW'(ND - 1 - i);
    end
  end

  // class resolution
  logic            a_zero, b_zero;
  logic [1:0]      sp_cls;
  logic [8*ND-1:0] sp_sig;
  logic            sp_inv;
  logic [LZW-1:0]  sp_lz;
  assign a_zero = (asig_q == '0);
  assign b_zero = (bsig_q == '0);

  always_comb begin
    sp_cls = CLS_FIN;
    sp_sig = prod_w;
    sp_inv = 1'b0;
    if (acls_q == CLS_SNAN) begin
      sp_cls = CLS_QNAN; sp_sig = {{(4*ND){1'b0}}, asig_q}; sp_inv = 1'b1;
    end else if (bcls_q == CLS_SNAN) begin
      sp_cls = CLS_QNAN; sp_sig = {{(4*ND){1'b0}}, bsig_q}; sp_inv = 1'b1;
    end else if (acls_q == CLS_QNAN) begin
      sp_cls = CLS_QNAN; sp_sig = {{(4*ND){1'b0}}, asig_q};
    end else if (bcls_q == CLS_QNAN) begin
      sp_cls = CLS_QNAN; sp_sig = {{(4*ND){1'b0}}, bsig_q};
    end else if ((acls_q == CLS_INF && bcls_q == CLS_FIN && b_zero) ||
                 (bcls_q == CLS_INF && acls_q == CLS_FIN && a_zero)) begin
      sp_cls = CLS_QNAN; sp_sig = '0; sp_inv = 1'b1;
    end else if (acls_q == CLS_INF || bcls_q == CLS_INF) begin
      sp_cls = CLS_INF; sp_sig = '0;
    end
    sp_lz = (sp_cls == CLS_FIN) ? LZW'(lza + lzb) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      acls_q <= '0; bcls_q <= '0; asgn_q <= 1'b0; bsgn_q <= 1'b0;
      aexp_q <= '0; bexp_q <= '0; asig_q <= '0; bsig_q <= '0; bsh_q <= '0;
      m1_q <= '0; m2_q <= '0; m5_q <= '0; m10_q <= '0;
      hi_q <= '0; lo_q <= '0; cnt_q <= '0;
      done <= 1'b0;
      r_cls <= '0; r_sign <= 1'b0; r_exp <= '0; r_sig <= '0; r_invalid <= 1'b0; r_lz <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          acls_q <= a_cls; bcls_q <= b_cls;
          asgn_q <= a_sign; bsgn_q <= b_sign;
          aexp_q <= a_exp; bexp_q <= b_exp;
          asig_q <= a_sig; bsig_q <= b_sig;
          st_q <= ST_PREP;
        end
        ST_PREP: begin
          m1_q  <= {4'b0, asig_q};
          m2_q  <= m2_w;
          m5_q  <= m5_w;
          m10_q <= {asig_q, 4'b0};
          hi_q  <= '0;
          lo_q  <= '0;
          cnt_q <= '0;
          bsh_q <= bsig_q;
          st_q  <= ST_RUN;
        end
        ST_RUN: begin
          hi_q  <= {4'b0, acc_sum[4*PD-1:4]};
          lo_q  <= {acc_sum[3:0], lo_q[4*ND-1:4]};
          bsh_q <= {4'b0, bsh_q[4*ND-1:4]};
          cnt_q <= cnt_q + CW'(1);
          if (last_step) begin
            st_q      <= ST_IDLE;
            done      <= 1'b1;
            r_cls     <= sp_cls;
            r_sig     <= sp_sig;
            r_invalid <= sp_inv;
            r_lz      <= sp_lz;
            r_sign    <= asgn_q ^ bsgn_q;
            r_exp     <= {aexp_q[EW-1], aexp_q} + {bexp_q[EW-1], bexp_q};
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [LTW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= '0;
    else if (busy)   lat_q <= lat_q + LTW'(1);
  end

  logic lz_ok;
  always_comb begin
    lz_ok = 1'b1;
    for (int i = 0; i < 2*ND; i++)
      if (i >= 2*ND - int'(r_lz) && r_sig[4*i +: 4] != 4'd0) lz_ok = 1'b0;
  end

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LTW'(ND + 1)));
  p_ignore_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(asig_q) && $stable(bsig_q)));
  p_pp_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (pp_cout == rc_neg));
  p_multiples_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PREP) |-> !mult_ovf);
  p_acc_no_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> !acc_cout);
  p_no_spill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |-> (acc_sum[4*PD-1 -: 4] == 4'd0));
  p_lz_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_cls == CLS_FIN) |-> lz_ok);
  p_invalid_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_invalid) |-> (r_cls == CLS_QNAN));

  for (genvar d = 0; d < PD; d++) begin : g_chk_dig
    p_digit_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q[4*d +: 4] <= 4'd9);
  end

endmodule

// File: tb/bcd_sig_mul_bench.sv
`timescale 1ns/1ps
module bcd_sig_mul_bench;
  localparam int ND  = 7;
  localparam int EW  = 10;
  localparam int LZW = $clog2(2*ND+1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      a_cls = '0, b_cls = '0;
  logic            a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0]   a_exp = '0, b_exp = '0;
  logic [4*ND-1:0] a_sig = '0, b_sig = '0;
  logic            busy, done, r_sign, r_invalid;
  logic [1:0]      r_cls;
  logic [EW:0]     r_exp;
  logic [8*ND-1:0] r_sig;
  logic [LZW-1:0]  r_lz;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bcd_sig_mul #(.ND(ND), .EW(EW)) u_bcd_sig_mul (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
    .busy(busy), .done(done), .r_cls(r_cls), .r_sign(r_sign), .r_exp(r_exp),
    .r_sig(r_sig), .r_invalid(r_invalid), .r_lz(r_lz));

  function automatic logic [8*ND-1:0] to_bcd(input longint v);
    logic [8*ND-1:0] r;
    longint t;
    t = v;
    for (int i = 0; i < 2*ND; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int lead_zeros(input longint v);
    int n;
    longint t;
    n = 0;
    t = v;
    while (t > 0) begin n++; t = t / 10; end
    return ND - n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One operation; the model is walked cycle by cycle against busy/done
  task automatic run_op(input int ca, input bit sa, input int ea, input longint va,
                        input int cb, input bit sb, input int eb, input longint vb,
                        input string req, input bit poke);
    int     e_cls;
    longint e_sig;
    bit     e_inv;
    int     e_lz;
    logic [8*ND-1:0] e_bcd, a_full, b_full;
    @(negedge clk);
    a_cls = 2'(ca); a_sign = sa; a_exp = EW'(ea); a_full = to_bcd(va); a_sig = a_full[4*ND-1:0];
    b_cls = 2'(cb); b_sign = sb; b_exp = EW'(eb); b_full = to_bcd(vb); b_sig = b_full[4*ND-1:0];
    start = 1'b1;

    e_inv = 1'b0; e_cls = 0; e_sig = va * vb;
    if (ca == 3)      begin e_cls = 2; e_sig = va; e_inv = 1'b1; end
    else if (cb == 3) begin e_cls = 2; e_sig = vb; e_inv = 1'b1; end
    else if (ca == 2) begin e_cls = 2; e_sig = va; end
    else if (cb == 2) begin e_cls = 2; e_sig = vb; end
    else if ((ca == 1 && cb == 0 && vb == 0) || (cb == 1 && ca == 0 && va == 0)) begin
      e_cls = 2; e_sig = 0; e_inv = 1'b1;
    end else if (ca == 1 || cb == 1) begin e_cls = 1; e_sig = 0; end
    e_lz  = (e_cls == 0) ? lead_zeros(va) + lead_zeros(vb) : 0;
    e_bcd = to_bcd(e_sig);

    for (int k = 0; k <= ND; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (poke && k == 3) begin
        a_sig = '0; b_sig = to_bcd(5)[4*ND-1:0]; a_cls = 2'd3; start = 1'b1;
      end
      if (poke && k == 4) start = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, "R1", "busy/done in flight",
          {busy, done}, 2'b10);
    end
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R1", "done strobe", {busy, done}, 2'b01);
    chk(r_sig === e_bcd, req, "significand", r_sig, e_bcd);
    chk(r_cls === 2'(e_cls), req, "class", r_cls, e_cls);
    chk(r_invalid === e_inv, req, "invalid", r_invalid, e_inv);
    chk(r_sign === (sa ^ sb), "R4", "sign", r_sign, sa ^ sb);
    chk(int'($signed(r_exp)) == ea + eb, "R4", "exponent", int'($signed(r_exp)), ea + eb);
    chk(int'(r_lz) == e_lz, "R9", "lz hint", r_lz, e_lz);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "reset handshake", {busy, done}, 0);
    chk(r_sig === '0 && r_cls === 2'd0, "R1", "reset result", r_sig, 0);
    rst_n = 1'b1;

    // R2: worked product and carry-heavy cases
    run_op(0, 0,   3, 1963,    0, 1,  -5, 8145,    "R2", 1'b0);
    run_op(0, 1,  20, 9999999, 0, 1,   7, 9999999, "R2", 1'b0);
    run_op(0, 0,   0, 5000000, 0, 0,   0, 2000000, "R2", 1'b0);
    // R3: every multiplier digit, including the subtracted recodings
    run_op(0, 0,   1, 7654321, 0, 0,   2, 8901234, "R3", 1'b0);
    run_op(0, 1,  -9, 2468024, 0, 0,   4, 5678901, "R3", 1'b0);
    run_op(0, 0,   0, 9999999, 0, 0,   0, 4848484, "R3", 1'b0);
    run_op(0, 0,   0, 1,       0, 0,   0, 9876543, "R3", 1'b0);
    // R1: start while busy is ignored
    run_op(0, 0,   6, 3141592, 0, 0,  -6, 2718281, "R1", 1'b1);
    // R4: exponent extremes
    run_op(0, 0, 511, 12,      0, 1, 511, 34,      "R4", 1'b0);
    run_op(0, 1, -512, 99,     0, 1, -512, 11,     "R4", 1'b0);
    // R10: finite zero
    run_op(0, 0,   2, 0,       0, 1,   1, 1234567, "R10", 1'b0);
    // R5 / R6: NaN handling and priority
    run_op(3, 0,   0, 1234,    2, 0,   0, 777,     "R5", 1'b0);
    run_op(2, 1,   0, 55,      3, 0,   0, 4321,    "R5", 1'b0);
    run_op(0, 0,   0, 8,       3, 0,   0, 9000001, "R5", 1'b0);
    run_op(2, 0,   0, 42,      0, 0,   0, 3,       "R6", 1'b0);
    run_op(0, 0,   0, 42,      2, 1,   0, 600,     "R6", 1'b0);
    run_op(2, 0,   0, 11,      2, 0,   0, 22,      "R6", 1'b0);
    // R7: zero times infinity in both orders
    run_op(0, 0,   0, 0,       1, 1,   0, 0,       "R7", 1'b0);
    run_op(1, 0,   0, 0,       0, 0,   0, 0,       "R7", 1'b0);
    // R8: infinity results
    run_op(1, 1,   0, 0,       0, 0,   0, 5,       "R8", 1'b0);
    run_op(1, 0,   0, 0,       1, 0,   0, 0,       "R8", 1'b0);

    @(negedge clk);
    chk(done === 1'b0, "R1", "done drops", done, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule